// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block is a combinational 8-bit arithmetic and logic unit. It takes an accumulator operand and a second operand and produces a result byte and a status byte. The operations are add, add with carry, subtract, subtract with borrow, the three bitwise logic operations, and a group of one-bit rotates and shifts. The status byte reports sign, zero, nibble carry, a shared parity/overflow bit, a subtract indicator and carry. The nibble carry and the subtract indicator are kept so that a later decimal-correction step can use them.

A flag register holds the last status byte. A write strobe captures the freshly computed status. A separate load strobe writes a raw byte into the register and takes priority over the write strobe. The stored carry bit feeds the carry-in of the carry-using operations. Surrounding control logic picks an operation code each cycle and decides whether its status should be kept.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 0) gives A+B, and ADC (code 1) gives A+B plus stored flag bit 0. Flag bit 0 (C) is set to the carry out of bit 7.
- R2: SUB (code 2) gives A-B, and SBC (code 3) gives A-B minus stored flag bit 0. C is set when a borrow occurs. SUB ignores the stored carry.
- R3: For codes 0 to 3, flag bit 2 (P/V) is set exactly when the signed two's-complement result falls outside -128..+127.
- R4: For codes 0 to 3, flag bit 4 (H) is the carry or borrow between bit 3 and bit 4.
- R5: Flag bit 1 (N) is 1 after SUB and SBC, and 0 after every other defined operation.
- R6: For all defined codes, flag bit 7 (S) equals result bit 7, and flag bit 6 (Z) is 1 exactly when the result is 0x00.
- R7: AND (4), OR (5) and XOR (6) give the bitwise result. P/V is set when the result has an even number of ones. H is 1 for AND and 0 for OR and XOR. N and C are 0.
- R8: The shift group is RLC (7), RRC (8), RL (9), RR (10), SLA (11), SRA (12) and SRL (13). Each moves A by one bit and sets C to the bit shifted out. The bit shifted in is as follows: the outgoing bit for RLC and RRC, the stored C for RL and RR, 0 for SLA and SRL, and the old bit 7 for SRA. P/V holds even parity. H and N are 0.
- R9: For every defined code, flag bits 5 and 3 of the computed status are 0.
- R10: The flag register resets to 0x00. On a rising edge it takes the load value when the load strobe is high. Otherwise it takes the computed status when the write strobe is high. Otherwise it holds.
- R11: Codes 14 and 15 pass A to the result and present the stored flag byte unchanged as the computed status.
- R12: The shift group ignores operand B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| accIn | input | 8 | Accumulator operand A |
| operandIn | input | 8 | Second operand B |
| flagWe | input | 1 | Capture the computed status on the next edge |
| flagLoad | input | 1 | Load flagLoadVal into the flag register (priority) |
| flagLoadVal | input | 8 | Raw byte for the load |
| result | output | 8 | Operation result |
| flagsNext | output | 8 | Computed status byte |
| flags | output | 8 | Stored flag byte |

## Verification
Overflow and carry share one addition, and these two can fall in the same cycle. They are provoked by the operand pairs 0x78+0x69, 0xFB+0xF0 and 0x80+0x80, which cover overflow without carry, carry without overflow, and both together with a zero result. Each pair is judged against status bytes worked out by hand. The second collision is a load strobe and a write strobe in the same cycle. It is provoked by raising both strobes while an operation with a different status is applied. The check passes only if the stored byte equals the load value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_RLC  = 4'd7,
    OP_RRC  = 4'd8,
    OP_RL   = 4'd9,
    OP_RR   = 4'd10,
    OP_SLA  = 4'd11,
    OP_SRA  = 4'd12,
    OP_SRL  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logicSel_e;

  // fill source for the bit entering a shift
  typedef enum logic [1:0] {
    SH_CIRC  = 2'd0,
    SH_THRU  = 2'd1,
    SH_ARITH = 2'd2,
    SH_ZERO  = 2'd3
  } shKind_e;

  typedef struct packed {
    logic      arith;
    logic      sub;
    logic      useCarry;
    logic      logicOp;
    logicSel_e lsel;
    logic      shift;
    logic      left;
    shKind_e   skind;
    logic      hold;
  } aluCtrl_t;

  // status byte bit positions (decoded by downstream condition logic)
  localparam int FLAG_S = 7;
  localparam int FLAG_Z = 6;
  localparam int FLAG_H = 4;
  localparam int FLAG_P = 2;
  localparam int FLAG_N = 1;
  localparam int FLAG_C = 0;
  localparam int FLAG_W = 8;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [3:0] op,
  output aluCtrl_t   ctrl
);

  aluOp_e opE;
  assign opE = aluOp_e'(op);

  always_comb begin
    ctrl = '0;
    ctrl.lsel  = LG_AND;
    ctrl.skind = SH_CIRC;
    unique case (opE)
      OP_ADD: ctrl.arith = 1'b1;
      OP_ADC: begin ctrl.arith = 1'b1; ctrl.useCarry = 1'b1; end
      OP_SUB: begin ctrl.arith = 1'b1; ctrl.sub = 1'b1; end
      OP_SBC: begin ctrl.arith = 1'b1; ctrl.sub = 1'b1; ctrl.useCarry = 1'b1; end
      OP_AND: begin ctrl.logicOp = 1'b1; ctrl.lsel = LG_AND; end
      OP_OR:  begin ctrl.logicOp = 1'b1; ctrl.lsel = LG_OR;  end
      OP_XOR: begin ctrl.logicOp = 1'b1; ctrl.lsel = LG_XOR; end
      OP_RLC: begin ctrl.shift = 1'b1; ctrl.left = 1'b1; ctrl.skind = SH_CIRC;  end
      OP_RRC: begin ctrl.shift = 1'b1; ctrl.left = 1'b0; ctrl.skind = SH_CIRC;  end
      OP_RL:  begin ctrl.shift = 1'b1; ctrl.left = 1'b1; ctrl.skind = SH_THRU;  end
      OP_RR:  begin ctrl.shift = 1'b1; ctrl.left = 1'b0; ctrl.skind = SH_THRU;  end
      OP_SLA: begin ctrl.shift = 1'b1; ctrl.left = 1'b1; ctrl.skind = SH_ZERO;  end
      OP_SRA: begin ctrl.shift = 1'b1; ctrl.left = 1'b0; ctrl.skind = SH_ARITH; end
      OP_SRL: begin ctrl.shift = 1'b1; ctrl.left = 1'b0; ctrl.skind = SH_ZERO;  end
      default: ctrl.hold = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aluCtrl_t          ctrl,
  input  logic [DW-1:0]     accIn,
  input  logic [DW-1:0]     operandIn,
  input  logic              flagWe,
  input  logic              flagLoad,
  input  logic [FLAG_W-1:0] flagLoadVal,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flagsNext,
  output logic [FLAG_W-1:0] flags
);

  localparam int NW = DW / 2;

  logic          storedC;
  logic          carryIn;
  logic [DW:0]   addFull;
  logic [DW:0]   subFull;
  logic [NW:0]   addNib;
  logic [NW:0]   subNib;
  logic [DW-1:0] arithRes;
  logic [DW-1:0] logicRes;
  logic [DW-1:0] shiftRes;
  logic          shiftOut;
  logic          fillBit;
  logic          aSign;
  logic          bSign;
  logic          rSign;
  logic          ovf;

  assign storedC = flags[FLAG_C];
  assign carryIn = ctrl.useCarry & storedC;

  // adder and subtractor, full width and low nibble
  always_comb begin
    addFull = {1'b0, accIn} + {1'b0, operandIn} + {{DW{1'b0}}, carryIn};
    subFull = {1'b0, accIn} - {1'b0, operandIn} - {{DW{1'b0}}, carryIn};
    addNib  = {1'b0, accIn[NW-1:0]} + {1'b0, operandIn[NW-1:0]} + {{NW{1'b0}}, carryIn};
    subNib  = {1'b0, accIn[NW-1:0]} - {1'b0, operandIn[NW-1:0]} - {{NW{1'b0}}, carryIn};
    arithRes = ctrl.sub ? subFull[DW-1:0] : addFull[DW-1:0];
  end

  assign aSign = accIn[DW-1];
  assign bSign = operandIn[DW-1];
  assign rSign = arithRes[DW-1];
  assign ovf   = ctrl.sub ? ((aSign != bSign) && (rSign != aSign))
                          : ((aSign == bSign) && (rSign != aSign));

  always_comb begin
    unique case (ctrl.lsel)
      LG_OR:   logicRes = accIn | operandIn;
      LG_XOR:  logicRes = accIn ^ operandIn;
      default: logicRes = accIn & operandIn;
    endcase
  end

  // one-bit shifter: choose the incoming bit, then move
  always_comb begin
    shiftOut = ctrl.left ? accIn[DW-1] : accIn[0];
    unique case (ctrl.skind)
      SH_CIRC:  fillBit = shiftOut;
      SH_THRU:  fillBit = storedC;
      SH_ARITH: fillBit = ctrl.left ? 1'b0 : accIn[DW-1];
      default:  fillBit = 1'b0;
    endcase
    shiftRes = ctrl.left ? {accIn[DW-2:0], fillBit} : {fillBit, accIn[DW-1:1]};
  end

  logic fC, fH, fP, fN;

  always_comb begin
    result = accIn;
    fC = 1'b0;
    fH = 1'b0;
    fP = 1'b0;
    fN = 1'b0;
    if (ctrl.arith) begin
      result = arithRes;
      fC = ctrl.sub ? subFull[DW] : addFull[DW];
      fH = ctrl.sub ? subNib[NW] : addNib[NW];
      fP = ovf;
      fN = ctrl.sub;
    end else if (ctrl.logicOp) begin
      result = logicRes;
      fH = (ctrl.lsel == LG_AND);
      fP = ~^logicRes;
    end else if (ctrl.shift) begin
      result = shiftRes;
      fC = shiftOut;
      fP = ~^shiftRes;
    end
  end

  always_comb begin
    if (ctrl.hold) begin
      flagsNext = flags;
    end else begin
      flagsNext = '0;
      flagsNext[FLAG_S] = result[DW-1];
      flagsNext[FLAG_Z] = (result == '0);
      flagsNext[FLAG_H] = fH;
      flagsNext[FLAG_P] = fP;
      flagsNext[FLAG_N] = fN;
      flagsNext[FLAG_C] = fC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (flagLoad) begin
      flags <= flagLoadVal;
    end else if (flagWe) begin
      flags <= flagsNext;
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [DW-1:0]     accIn,
  input  logic [DW-1:0]     operandIn,
  input  logic              flagWe,
  input  logic              flagLoad,
  input  logic [FLAG_W-1:0] flagLoadVal,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flagsNext,
  output logic [FLAG_W-1:0] flags
);

  aluCtrl_t ctrl;

  alu8_ctrl u_ctrl (
    .op   (op),
    .ctrl (ctrl)
  );

  alu8_datapath #(.DW(DW)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .accIn       (accIn),
    .operandIn   (operandIn),
    .flagWe      (flagWe),
    .flagLoad    (flagLoad),
    .flagLoadVal (flagLoadVal),
    .result      (result),
    .flagsNext   (flagsNext),
    .flags       (flags)
  );

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op,
  input logic [7:0] accIn,
  input logic [7:0] operandIn,
  input logic       flagWe,
  input logic       flagLoad,
  input logic [7:0] flagLoadVal,
  input logic [7:0] result,
  input logic [7:0] flagsNext,
  input logic [7:0] flags
);

  logic isRsv, isSubOp, isAddOp, isLogicOp;
  assign isRsv     = (op >= 4'd14);
  assign isSubOp   = (op == 4'd2) || (op == 4'd3);
  assign isAddOp   = (op == 4'd0) || (op == 4'd1);
  assign isLogicOp = (op >= 4'd4) && (op <= 4'd6);

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flagWe && !flagLoad) |=> $stable(flags));

  assert_flags_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flagLoad |=> (flags == $past(flagLoadVal)));

  assert_flags_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flagWe && !flagLoad) |=> (flags == $past(flagsNext)));

  assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !isRsv |-> (flagsNext[5] == 1'b0 && flagsNext[3] == 1'b0));

  assert_sub_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isSubOp |-> flagsNext[1]);

  assert_add_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isAddOp |-> !flagsNext[1]);

  assert_logic_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    isLogicOp |-> (flagsNext[1:0] == 2'b00 && flagsNext[4] == (op == 4'd4)));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !isRsv |-> (flagsNext[6] == (result == 8'h00)));

  assert_reserved_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    isRsv |-> (result == accIn && flagsNext == flags));

endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] accIn = 8'h00;
  logic [7:0] operandIn = 8'h00;
  logic       flagWe = 1'b0;
  logic       flagLoad = 1'b0;
  logic [7:0] flagLoadVal = 8'h00;
  logic [7:0] result;
  logic [7:0] flagsNext;
  logic [7:0] flags;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  alu8_core u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .accIn       (accIn),
    .operandIn   (operandIn),
    .flagWe      (flagWe),
    .flagLoad    (flagLoad),
    .flagLoadVal (flagLoadVal),
    .result      (result),
    .flagsNext   (flagsNext),
    .flags       (flags)
  );

  // {op, A, B, stored C, expected result, expected status}
  // Status bits: 7 S, 6 Z, 4 H, 2 P/V, 1 N, 0 C; bits 5 and 3 zero (R9)
  localparam int NV = 27;
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  8'h78, 8'h69, 1'b0, 8'hE1, 8'h94}, // R3 overflow, no carry
    {4'd0,  8'hFB, 8'hF0, 1'b0, 8'hEB, 8'h81}, // carry, no overflow
    {4'd0,  8'h80, 8'h80, 1'b0, 8'h00, 8'h45}, // both, R6 zero
    {4'd1,  8'h0F, 8'h00, 1'b1, 8'h10, 8'h10}, // R4 nibble carry
    {4'd1,  8'hFF, 8'h00, 1'b1, 8'h00, 8'h51},
    {4'd1,  8'hFF, 8'h00, 1'b0, 8'hFF, 8'h80},
    {4'd2,  8'h10, 8'h01, 1'b0, 8'h0F, 8'h12}, // R5 N set
    {4'd2,  8'h00, 8'h01, 1'b0, 8'hFF, 8'h93},
    {4'd2,  8'h80, 8'h01, 1'b0, 8'h7F, 8'h16},
    {4'd2,  8'h55, 8'h55, 1'b1, 8'h00, 8'h42}, // stored C ignored
    {4'd2,  8'h7F, 8'hFF, 1'b0, 8'h80, 8'h87},
    {4'd3,  8'h00, 8'h00, 1'b1, 8'hFF, 8'h93},
    {4'd3,  8'h50, 8'h20, 1'b1, 8'h2F, 8'h12},
    {4'd4,  8'hF0, 8'h3C, 1'b0, 8'h30, 8'h14},
    {4'd4,  8'h0F, 8'hF0, 1'b1, 8'h00, 8'h54},
    {4'd5,  8'h80, 8'h01, 1'b1, 8'h81, 8'h84},
    {4'd6,  8'hFF, 8'h01, 1'b0, 8'hFE, 8'h80},
    {4'd6,  8'hAA, 8'hAA, 1'b0, 8'h00, 8'h44},
    {4'd7,  8'h81, 8'hA5, 1'b0, 8'h03, 8'h05},
    {4'd8,  8'h01, 8'hA5, 1'b0, 8'h80, 8'h81},
    {4'd9,  8'h80, 8'hA5, 1'b0, 8'h00, 8'h45},
    {4'd9,  8'h01, 8'hA5, 1'b1, 8'h03, 8'h04},
    {4'd10, 8'h01, 8'hA5, 1'b1, 8'h80, 8'h81},
    {4'd11, 8'hC0, 8'hA5, 1'b0, 8'h80, 8'h81},
    {4'd12, 8'h81, 8'hA5, 1'b0, 8'hC0, 8'h85},
    {4'd13, 8'h81, 8'hA5, 1'b0, 8'h40, 8'h01},
    {4'd13, 8'h02, 8'h5A, 1'b1, 8'h01, 8'h00}
  };

  function automatic string tagFor(input logic [3:0] o);
    if (o <= 4'd1)      return "R1 R3 R4 R5 R6 R9";
    else if (o <= 4'd3) return "R2 R3 R4 R5 R6 R9";
    else if (o <= 4'd6) return "R7 R5 R6 R9";
    else                return "R8 R12 R5 R6 R9";
  endfunction

  task automatic check8(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
    end
  endtask

  task automatic loadFlags(input logic [7:0] v);
    @(negedge clk);
    flagLoad = 1'b1;
    flagLoadVal = v;
    @(posedge clk);
    #1;
    flagLoad = 1'b0;
  endtask

  task automatic writeFlags();
    @(negedge clk);
    flagWe = 1'b1;
    @(posedge clk);
    #1;
    flagWe = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #12;
    check8("R10", "flags during reset", flags, 8'h00);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check8("R10", "flags after reset", flags, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      loadFlags({7'b0, v[16]});
      @(negedge clk);
      op = v[36:33];
      accIn = v[32:25];
      operandIn = v[24:17];
      #1;
      check8(tagFor(v[36:33]), "result", result, v[15:8]);
      check8(tagFor(v[36:33]), "status", flagsNext, v[7:0]);
      writeFlags();
      check8("R10", "stored status", flags, v[7:0]);
    end

    // R12: same shift with a different B gives the same outputs
    loadFlags(8'h00);
    @(negedge clk);
    op = 4'd7; accIn = 8'h81; operandIn = 8'h00;
    #1;
    check8("R12", "RLC result, B=00", result, 8'h03);
    operandIn = 8'hFF;
    #1;
    check8("R12", "RLC result, B=FF", result, 8'h03);
    check8("R12", "RLC status, B=FF", flagsNext, 8'h05);

    // R10: no strobe -> hold
    loadFlags(8'h3C);
    @(negedge clk);
    op = 4'd0; accIn = 8'h00; operandIn = 8'h00;
    @(posedge clk);
    #1;
    check8("R10", "hold without strobe", flags, 8'h3C);

    // R10: load beats write in the same cycle
    @(negedge clk);
    flagWe = 1'b1; flagLoad = 1'b1; flagLoadVal = 8'hA5;
    @(posedge clk);
    #1;
    flagWe = 1'b0; flagLoad = 1'b0;
    check8("R10", "load priority", flags, 8'hA5);

    // R11: reserved codes pass A and the stored byte
    for (int c = 14; c < 16; c++) begin
      @(negedge clk);
      op = 4'(c); accIn = 8'h6B; operandIn = 8'h11;
      #1;
      check8("R11", "reserved result", result, 8'h6B);
      check8("R11", "reserved status", flagsNext, 8'hA5);
      writeFlags();
      check8("R11", "reserved stored", flags, 8'hA5);
    end

    // R10: reset mid-run clears
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check8("R10", "async reset clear", flags, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule